// File: doc/BRIEF.md
# Translation buffer pointer generator

This block computes where a missed translation is likely to be found in a software-managed, in-memory translation buffer. It holds a tag register that carries a faulting virtual page and its context number. It also holds two buffer base registers and one configuration register for each context group. One group serves context zero and the other serves every nonzero context. From these registers it forms two pointers into the buffer, one for the small page-size class and one for the large page-size class.

Software writes and reads the seven registers through a simple synchronous write port and a combinational read port. The walker that fetches entries from the pointed-to locations sits outside this block. Both pointers are pure functions of the stored registers, so they settle in the cycle after any register write.

Top module: `xbuf_ptr_gen`

## Requirements
- R1: After reset every register reads zero and both pointer outputs are zero.
- R2: Register codes are 0 tag, 1 zero-context base small, 2 zero-context base large, 3 zero-context config, 4 nonzero-context base small, 5 nonzero-context base large, 6 nonzero-context config. A write is captured at the clock edge, and from the next cycle a read of that code returns the full written word.
- R3: Code 7 reads zero. A write to code 7 changes no register and no pointer.
- R4: When tag bits 12:0 are all zero, the pointers use the zero-context base and config registers. Otherwise they use the nonzero-context ones.
- R5: Pointer bits 63:13 start as the selected base bits 63:13. Base bits 11:4 never reach a pointer, and pointer bits 3:0 are always zero.
- R6: The page code (3 bits) is config bits 2:0 for the small-class pointer and config bits 10:8 for the large-class pointer.
- R7: With base bit 12 (split) set, the large-class pointer also has bit 13+S set, where S is base bits 3:0. The small-class pointer ignores base bit 12.
- R8: The tag shifted right by 9+3*P, where P is the page code, is masked to bits 12+S down to 4 and ORed into the pointer.
- R9: The pointers reflect a register write in the cycle after it and hold their value while no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write enable |
| waddr_i | input | 3 | Register code for the write |
| wdata_i | input | 64 | Write data |
| raddr_i | input | 3 | Register code for the read |
| rdata_o | output | 64 | Read data (combinational) |
| ptr_a_o | output | 64 | Small page-size class pointer |
| ptr_b_o | output | 64 | Large page-size class pointer |

## Verification
A bad stored register shows up on the read port in the first cycle it is addressed. If the register feeds the active context group, it also corrupts a pointer at once. A wrong context choice, page-code field or split decision leaves the high pointer bits or the index field inconsistent in the cycle after the triggering write. A reference model that compares both pointers and the read data on every clock therefore catches the error within one cycle of its cause.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  localparam int REG_AW    = 3;
  localparam int NREG      = 7;
  localparam int CTX_W     = 13;
  localparam int PAGE_LSB  = 13;
  localparam int SPLIT_BIT = 12;
  localparam int SZ_W      = 4;
  localparam int PC_W      = 3;
  localparam int PC_A_LSB  = 0;
  localparam int PC_B_LSB  = 8;
  localparam int IDX_SHIFT = 9;
  localparam int IDX_LSB   = 4;
  localparam int HI_KEEP   = 29;  // lowest base bit never touched by index or split
  localparam int SH_W      = 6;

  typedef enum logic [REG_AW-1:0] {
    XR_TAG      = 3'd0,
    XR_Z_BASE_A = 3'd1,
    XR_Z_BASE_B = 3'd2,
    XR_Z_CFG    = 3'd3,
    XR_N_BASE_A = 3'd4,
    XR_N_BASE_B = 3'd5,
    XR_N_CFG    = 3'd6,
    XR_NONE     = 3'd7
  } xreg_e;
endpackage

// File: rtl/xbuf_regs.sv
module xbuf_regs import xbuf_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_AW-1:0]             waddr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [REG_AW-1:0]             raddr_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NREG-1:0][DATA_W-1:0]   regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_o[g] <= '0;
      else if (we_i && waddr_i == REG_AW'(g))         regs_o[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr_i == REG_AW'(i)) rdata_o = regs_o[i];
  end
endmodule

// File: rtl/xbuf_ptr_calc.sv
module xbuf_ptr_calc import xbuf_pkg::*; #(
  parameter int DATA_W  = 64,
  parameter bit CLASS_B = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tag_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] cfg_i,
  output logic [DATA_W-1:0] ptr_o
);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);
  localparam logic [DATA_W-1:0] LOW_CLR = DATA_W'((1 << IDX_LSB) - 1);

  logic [SZ_W-1:0]   sz;
  logic [PC_W-1:0]   pc;
  logic              split;
  logic [SH_W-1:0]   shamt;
  logic [SH_W-1:0]   top_p1;
  logic [DATA_W-1:0] mask, idx, split_v, base_hi;
  logic              unused_bits;

  assign sz = base_i[SZ_W-1:0];

  if (CLASS_B) begin : g_b
    assign pc    = cfg_i[PC_B_LSB +: PC_W];
    assign split = base_i[SPLIT_BIT];
  end else begin : g_a
    assign pc    = cfg_i[PC_A_LSB +: PC_W];
    assign split = 1'b0;
  end

  assign unused_bits = ^{base_i[SPLIT_BIT:IDX_LSB], cfg_i};

  assign shamt   = SH_W'(IDX_SHIFT) + SH_W'(pc) * SH_W'(3);
  assign top_p1  = SH_W'(PAGE_LSB) + SH_W'(sz);   // one above top index bit
  assign mask    = ((ONE << top_p1) - ONE) & ~LOW_CLR;
  assign idx     = (tag_i >> shamt) & mask;
  assign split_v = split ? (ONE << top_p1) : '0;
  assign base_hi = {base_i[DATA_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign ptr_o   = base_hi | split_v | idx;

  assert_low_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o[IDX_LSB-1:0] == '0);
  assert_upper_base_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o[DATA_W-1:HI_KEEP] == base_i[DATA_W-1:HI_KEEP]);
  if (CLASS_B) begin : g_b_chk
    assert_split_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      base_i[SPLIT_BIT] |-> ptr_o[PAGE_LSB + int'(base_i[SZ_W-1:0])]);
  end
endmodule

// File: rtl/xbuf_ptr_gen.sv
module xbuf_ptr_gen import xbuf_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_AW-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ptr_a_o,
  output logic [DATA_W-1:0] ptr_b_o
);
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]           tag, cfg;
  logic [1:0][DATA_W-1:0]      base, ptr;
  logic                        ctx_zero;

  xbuf_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i, .raddr_i, .rdata_o,
    .regs_o(regs)
  );

  assign tag      = regs[int'(XR_TAG)];
  assign ctx_zero = (tag[CTX_W-1:0] == '0);
  assign base[0]  = ctx_zero ? regs[int'(XR_Z_BASE_A)] : regs[int'(XR_N_BASE_A)];
  assign base[1]  = ctx_zero ? regs[int'(XR_Z_BASE_B)] : regs[int'(XR_N_BASE_B)];
  assign cfg      = ctx_zero ? regs[int'(XR_Z_CFG)]    : regs[int'(XR_N_CFG)];

  for (genvar c = 0; c < 2; c++) begin : g_cls
    xbuf_ptr_calc #(.DATA_W(DATA_W), .CLASS_B(c == 1)) u_calc (
      .clk_i, .rst_ni,
      .tag_i (tag),
      .base_i(base[c]),
      .cfg_i (cfg),
      .ptr_o (ptr[c])
    );
  end

  assign ptr_a_o = ptr[0];
  assign ptr_b_o = ptr[1];

  assert_rd_after_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != XR_NONE) |=>
      (raddr_i != $past(waddr_i)) || (rdata_o == $past(wdata_i)));
  assert_none_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_i == XR_NONE) |-> (rdata_o == '0));
  assert_ctx_zero_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regs[int'(XR_TAG)][CTX_W-1:0] == '0) |->
      (ptr_a_o[DATA_W-1:HI_KEEP] == regs[int'(XR_Z_BASE_A)][DATA_W-1:HI_KEEP]));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(ptr_a_o) && $stable(ptr_b_o)));
endmodule

// File: tb/sim_xbuf_ptr_gen.sv
module sim_xbuf_ptr_gen;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  waddr_i = '0, raddr_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o, ptr_a_o, ptr_b_o;

  int n_cmp = 0, n_bad = 0;
  string rd_req = "R1", pt_req = "R1";
  logic [63:0] m [0:7];
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  xbuf_ptr_gen u0 (
    .clk_i(clk), .rst_ni, .we_i, .waddr_i, .wdata_i, .raddr_i,
    .rdata_o, .ptr_a_o, .ptr_b_o
  );

  function automatic logic [63:0] ref_ptr(bit cls_b);
    logic [63:0] t, b, cf, r;
    int sz, pc;
    t  = m[0];
    if (t[12:0] == 13'd0) begin b = cls_b ? m[2] : m[1]; cf = m[3]; end
    else                  begin b = cls_b ? m[5] : m[4]; cf = m[6]; end
    sz = int'(b[3:0]);
    pc = cls_b ? int'(cf[10:8]) : int'(cf[2:0]);
    r  = b & ~64'h1FFF;
    if (cls_b && b[12]) r[13 + sz] = 1'b1;
    for (int k = 4; k <= 12 + sz; k++) r[k] = r[k] | t[k + 9 + 3 * pc];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit we, logic [2:0] wa, logic [63:0] wd, logic [2:0] ra);
    we_i = we; waddr_i = wa; wdata_i = wd; raddr_i = ra;
    @(posedge clk);
    if (we && wa != 3'd7) m[wa] = wd;
    @(negedge clk);
    chk(rd_req, "rdata", rdata_o, m[ra]);
    chk(pt_req, "ptr_a", ptr_a_o, ref_ptr(1'b0));
    chk(pt_req, "ptr_b", ptr_b_o, ref_ptr(1'b1));
  endtask

  task automatic wr(logic [2:0] wa, logic [63:0] wd);
    cyc(1'b1, wa, wd, wa);
  endtask

  function automatic logic [63:0] nxt();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 7);
    lfsr = lfsr ^ (lfsr << 17);
    return lfsr;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd_req = "R1"; pt_req = "R1";
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'(i), '0, 3'(i));

    // R2 write / read every code; pointers follow (R9)
    rd_req = "R2"; pt_req = "R9";
    for (int i = 0; i < 7; i++) wr(3'(i), 64'hA5C3_0F1E_7B2D_4968 ^ (64'h1111 * i));
    for (int i = 0; i < 7; i++) cyc(1'b0, 3'(i), '0, 3'(i));

    // R3 code 7 ignored
    rd_req = "R3"; pt_req = "R3";
    cyc(1'b1, 3'd7, '1, 3'd7);
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'(i), '0, 3'(i));

    // R4 context group select
    rd_req = "R2"; pt_req = "R4";
    wr(3'd3, 64'h0); wr(3'd6, 64'h0);
    wr(3'd1, 64'h1111_0000_0000_0003); wr(3'd2, 64'h2222_0000_0000_0005);
    wr(3'd4, 64'h3333_0000_0000_0007); wr(3'd5, 64'h4444_0000_0000_0009);
    wr(3'd0, 64'h0000_0000_0F2E_6000);
    cyc(1'b0, 3'd0, '0, 3'd0);
    wr(3'd0, 64'h0000_0000_0F2E_6005);
    cyc(1'b0, 3'd0, '0, 3'd0);
    wr(3'd0, 64'h0000_0000_0F2E_7000);

    // R6 page code per class, nonzero context
    pt_req = "R6";
    wr(3'd0, 64'h0123_4567_89AB_C001);
    wr(3'd4, 64'h3333_0000_0000_000F); wr(3'd5, 64'h4444_0000_0000_000F);
    for (int pc = 0; pc < 8; pc++) wr(3'd6, (64'(7 - pc) << 8) | 64'(pc) | 64'hF0F0_0000_0000_F0F0);

    // R7 split bit on large class only
    pt_req = "R7";
    wr(3'd6, 64'h0000_0000_0000_0201);
    for (int sz = 0; sz < 16; sz++) begin
      wr(3'd5, 64'h4444_0000_0000_1000 | 64'(sz));
      wr(3'd4, 64'h3333_0000_0000_1000 | 64'(sz));
    end
    wr(3'd5, 64'h4444_0000_0000_0004);

    // R8 index field across sizes and tags
    pt_req = "R8";
    for (int sz = 0; sz < 16; sz++) begin
      wr(3'd4, 64'h3000_0000_0000_0000 | 64'(sz));
      wr(3'd5, 64'h4000_0000_0000_1000 | 64'(15 - sz));
      wr(3'd0, nxt() | 64'h1);
    end
    wr(3'd0, 64'hFFFF_FFFF_FFFF_E000);
    wr(3'd1, 64'h5000_0000_0000_000A); wr(3'd2, 64'h6000_0000_0000_000C);
    wr(3'd3, 64'h0000_0000_0000_0305);

    // R5 base low bits never leak
    pt_req = "R5";
    wr(3'd1, 64'hFFFF_FFFF_FFFF_EFF0);
    wr(3'd2, 64'hFFFF_FFFF_FFFF_EFF3);
    wr(3'd0, 64'h0);
    wr(3'd4, 64'hAAAA_AAAA_AAAA_AFF5);
    wr(3'd0, 64'h1);

    // R9 hold while idle
    pt_req = "R9";
    for (int i = 0; i < 10; i++) cyc(1'b0, 3'(i % 8), '0, 3'(i % 8));

    // mixed traffic
    rd_req = "R2"; pt_req = "R8";
    for (int i = 0; i < 400; i++) begin
      logic [63:0] r, d;
      r = nxt(); d = nxt();
      if (r[9:8] == 2'b00) d[12:0] = '0;
      cyc(r[6], r[2:0], d, r[5:3]);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule